// File: doc/BRIEF.md
# Program-Loop Watchdog Timer

This block watches for a program that has stopped making progress. Software picks a timeout from a 3-bit select code, picks whether expiry should request a system reset or raise a non-maskable interrupt, and then writes a run strobe. Every later run strobe restarts the interval. If the interval passes with no run strobe, the block raises the chosen expiry request and starts a new interval.

The count is taken from the main clock. An oscillator-mode input selects whether the main clock runs at the raw oscillator rate or at half that rate. Counting uses two stages. A free-running low stage of `PRE_BITS` bits feeds an upper stage, and a run strobe clears only the upper stage. A timeout can therefore end early by up to one low-stage period. Counting pauses while the CPU is in stop mode or runs from the subsystem clock. There is no input for halt mode, so counting goes on through halt. Once the first run strobe has been taken, the configuration is locked until the next system reset.

Top module: `loop_watchdog`

## Requirements
- R1: Select codes 0 to 6 give a timeout of 2^(BASE_EXP+code) main-clock ticks after a run strobe. BASE_EXP is 11 by default. Expiry comes no earlier than 2^PRE_BITS ticks before that nominal value and no later than the nominal value.
- R2: Select code 7 gives 2^(BASE_EXP+8) ticks, with the same allowed shortfall.
- R3: When `osc_div2` is 1, one main-clock tick takes two `clk` cycles, so every timeout doubles in `clk` cycles. When `osc_div2` is 0, one tick takes one `clk` cycle.
- R4: Counting requires both of these: the enable bit is 1, and a run strobe has been taken. Without them, no expiry request is ever raised.
- R5: Each run strobe clears the upper counting stage. Strobes spaced closer than the timeout prevent expiry, and the next timeout is measured from the last strobe.
- R6: When the action bit is 1, expiry drives `rst_req` high for exactly one cycle. `rst_req` and `nmi_req` are never high together.
- R7: When the action bit is 0, expiry sets `nmi_req`. It stays high until an `nmi_ack` strobe clears it at the next edge. The count restarts at each expiry, so expiries repeat every full timeout.
- R8: While `cpu_stop` or `cpu_subclk` is 1, both counting stages hold their values. When both inputs return to 0, counting resumes where it stopped.
- R9: After the first run strobe, configuration writes are ignored until reset. This covers the enable bit, the action bit and the select code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit: 1 lets the block count |
| cfg_rst_mode | input | 1 | Action bit: 1 selects the reset request, 0 selects the NMI |
| cfg_sel | input | 3 | Timeout select code |
| run_wr | input | 1 | Run strobe: starts counting and restarts the interval |
| osc_div2 | input | 1 | 1 makes the main clock half the oscillator rate |
| cpu_stop | input | 1 | CPU is in stop mode; counting pauses |
| cpu_subclk | input | 1 | CPU runs from the subsystem clock; counting pauses |
| nmi_ack | input | 1 | Strobe that acknowledges a pending NMI |
| rst_req | output | 1 | Single-cycle system reset request |
| nmi_req | output | 1 | Held non-maskable interrupt request |

## Verification
The assertions assume that `cpu_stop`, `cpu_subclk` and `nmi_ack` are already low when reset is released. A freeze check looks back one cycle, so a freeze input that is high during reset would fail that check on the first cycle. The bench holds all of these inputs low during every reset and only changes inputs on falling edges. The timing checks accept any expiry within a window, because the phase of the free-running low stage is unknown when a run strobe lands. Each window is as wide as one low-stage period plus the divider phase, and no wider. A timeout that is wrong by a power of two therefore still falls outside it.

// File: rtl/lw_pkg.sv
// Shared types and helpers for the program-loop watchdog.
// Assumes: the select code is 3 bits; code 7 skips one power of two.
package lw_pkg;

    typedef logic [2:0] lw_sel_t;

    // Extra exponent above the base for a select code (code 7 jumps to 8).
    function automatic logic [3:0] sel_to_exp(input lw_sel_t s);
        return (s == 3'b111) ? 4'd8 : {1'b0, s};
    endfunction

endpackage

// File: rtl/lw_tick_gen.sv
// Main-clock tick generation plus the free-running low prescaler stage.
// Produces a carry pulse each time the low stage wraps.
// Assumes: the freeze input already combines stop and subclock conditions.
module lw_tick_gen #(
    parameter int PRE_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_div2,
    input  logic freeze,
    output logic stage_carry
);

    logic                div_q;
    logic [PRE_BITS-1:0] pre_q;
    logic                tick;
    logic                step;

    assign tick        = !osc_div2 || div_q;
    assign step        = tick && !freeze;
    assign stage_carry = step && (&pre_q);

    // Half-rate phase toggle for the divided main clock.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= 1'b0;
        else        div_q <= !div_q;
    end

    // Low stage advances on every unfrozen tick; never cleared by a run strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (step) pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/lw_stage_counter.sv
// Upper counting stage: counts low-stage carries and flags expiry when the
// selected number of carries has been reached, then restarts from zero.
// Assumes: BASE_EXP > PRE_BITS; clear has priority over counting.
module lw_stage_counter
    import lw_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int PRE_BITS = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clear,
    input  logic    count_en,
    input  logic    carry,
    input  lw_sel_t sel,
    output logic    expire
);

    localparam int LOW_SPAN = BASE_EXP - PRE_BITS;
    localparam int UPW      = LOW_SPAN + 9;

    logic [UPW-1:0] up_q;
    logic [UPW-1:0] target;
    logic [UPW-1:0] last;
    logic [4:0]     shift;

    assign shift  = 5'(LOW_SPAN) + {1'b0, sel_to_exp(sel)};
    assign target = {{(UPW-1){1'b0}}, 1'b1} << shift;
    assign last   = target - 1'b1;
    assign expire = count_en && carry && !clear && (up_q == last);

    // Upper stage: cleared by run strobe, counts carries, wraps on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   up_q <= '0;
        else if (clear)               up_q <= '0;
        else if (count_en && carry)   up_q <= expire ? '0 : up_q + 1'b1;
    end

endmodule

// File: rtl/lw_ctrl.sv
// Configuration holding, lock after first run strobe, and expiry outputs.
// Assumes: expire is a single-cycle pulse; a new expiry outranks an ack.
module lw_ctrl
    import lw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cfg_we,
    input  logic    cfg_enable,
    input  logic    cfg_rst_mode,
    input  lw_sel_t cfg_sel,
    input  logic    run_wr,
    input  logic    expire,
    input  logic    nmi_ack,
    output logic    en_q,
    output lw_sel_t sel_q,
    output logic    running_q,
    output logic    rst_req,
    output logic    nmi_req
);

    logic mode_q;

    // Configuration register, writable only until the first run strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            mode_q <= 1'b0;
            sel_q  <= '0;
        end else if (cfg_we && !running_q) begin
            en_q   <= cfg_enable;
            mode_q <= cfg_rst_mode;
            sel_q  <= cfg_sel;
        end
    end

    // Run flag: set by the first run strobe, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      running_q <= 1'b0;
        else if (run_wr) running_q <= 1'b1;
    end

    // Reset request: one-cycle pulse per expiry in reset mode.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= expire && mode_q;
    end

    // NMI request: set by expiry in interrupt mode, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                  nmi_req <= 1'b0;
        else if (expire && !mode_q)  nmi_req <= 1'b1;
        else if (nmi_ack)            nmi_req <= 1'b0;
    end

endmodule

// File: rtl/loop_watchdog.sv
// Program-loop watchdog top: tick/prescaler, upper stage, control.
// Assumes: one oscillator clock domain; all strobes are one cycle wide.
module loop_watchdog
    import lw_pkg::*;
#(
    parameter int BASE_EXP = 11,
    parameter int PRE_BITS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_enable,
    input  logic       cfg_rst_mode,
    input  logic [2:0] cfg_sel,
    input  logic       run_wr,
    input  logic       osc_div2,
    input  logic       cpu_stop,
    input  logic       cpu_subclk,
    input  logic       nmi_ack,
    output logic       rst_req,
    output logic       nmi_req
);

    logic    freeze_w;
    logic    carry_w;
    logic    expire_w;
    logic    en_w;
    logic    running_w;
    logic    count_en_w;
    lw_sel_t sel_w;

    assign freeze_w   = cpu_stop || cpu_subclk;
    assign count_en_w = en_w && running_w && !freeze_w;

    lw_tick_gen #(.PRE_BITS(PRE_BITS)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_div2    (osc_div2),
        .freeze      (freeze_w),
        .stage_carry (carry_w)
    );

    lw_stage_counter #(.BASE_EXP(BASE_EXP), .PRE_BITS(PRE_BITS)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (run_wr),
        .count_en (count_en_w),
        .carry    (carry_w),
        .sel      (sel_w),
        .expire   (expire_w)
    );

    lw_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_enable   (cfg_enable),
        .cfg_rst_mode (cfg_rst_mode),
        .cfg_sel      (cfg_sel),
        .run_wr       (run_wr),
        .expire       (expire_w),
        .nmi_ack      (nmi_ack),
        .en_q         (en_w),
        .sel_q        (sel_w),
        .running_q    (running_w),
        .rst_req      (rst_req),
        .nmi_req      (nmi_req)
    );

endmodule

// File: rtl/lw_checker.sv
// Temporal checks on the watchdog, bound into loop_watchdog.
// Assumes: freeze and ack inputs are low while reset is asserted.
module lw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_stop,
    input logic       cpu_subclk,
    input logic       nmi_ack,
    input logic       cfg_we,
    input logic       running,
    input logic       expire,
    input logic [2:0] sel,
    input logic       rst_req,
    input logic       nmi_req
);

    a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && nmi_req));

    a_r7_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req && !nmi_ack |=> nmi_req);

    a_r7_nmi_ack: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack && !expire |=> !nmi_req);

    a_r8_no_nmi_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> !$past(cpu_stop) && !$past(cpu_subclk));

    a_r8_no_rst_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(cpu_stop) && !$past(cpu_subclk));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !rst_req && !nmi_req);

    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        running && cfg_we |=> $stable(sel));

endmodule

bind loop_watchdog lw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_stop   (cpu_stop),
    .cpu_subclk (cpu_subclk),
    .nmi_ack    (nmi_ack),
    .cfg_we     (cfg_we),
    .running    (running_w),
    .expire     (expire_w),
    .sel        (sel_w),
    .rst_req    (rst_req),
    .nmi_req    (nmi_req)
);

// File: tb/loop_watchdog_tb.sv
`timescale 1ns/1ps
module loop_watchdog_tb;

    localparam int BASE  = 6;
    localparam int PRE   = 2;
    localparam int PRE_N = 1 << PRE;

    // Vector fields: [4] action bit, [3] osc_div2, [2:0] select code.
    localparam logic [4:0] VEC [6] = '{
        5'b0_0_000, 5'b0_1_001, 5'b1_0_011,
        5'b0_0_110, 5'b0_0_111, 5'b1_1_010
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_rst_mode = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic run_wr = 1'b0, osc_div2 = 1'b0, cpu_stop = 1'b0, cpu_subclk = 1'b0, nmi_ack = 1'b0;
    logic rst_req, nmi_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = !clk;

    loop_watchdog #(.BASE_EXP(BASE), .PRE_BITS(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
        .cfg_rst_mode(cfg_rst_mode), .cfg_sel(cfg_sel), .run_wr(run_wr),
        .osc_div2(osc_div2), .cpu_stop(cpu_stop), .cpu_subclk(cpu_subclk),
        .nmi_ack(nmi_ack), .rst_req(rst_req), .nmi_req(nmi_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 0; run_wr = 0; cpu_stop = 0; cpu_subclk = 0; nmi_ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic configure(input bit en, input bit mode, input logic [2:0] sel);
        @(negedge clk);
        cfg_we = 1; cfg_enable = en; cfg_rst_mode = mode; cfg_sel = sel;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic kick();
        @(negedge clk); run_wr = 1;
        @(negedge clk); run_wr = 0;
    endtask

    function automatic int nominal(input logic [2:0] sel);
        return 1 << ((sel == 3'b111) ? BASE + 8 : BASE + int'(sel));
    endfunction

    // Count edges until an expiry output is seen, starting from a given count.
    task automatic measure(input int start, input int cap, output int cnt);
        cnt = start;
        while (!(nmi_req || rst_req) && cnt < cap) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    task automatic check_window(input string req, input int cnt, input int n, input int m);
        int lo, hi;
        lo = (n - PRE_N) * m;
        hi = (n + 1) * m + 2;
        check(cnt >= lo && cnt <= hi, req, cnt, n * m);
    endtask

    initial begin
        #(190000 * 20);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        int n;
        // Reset state
        do_reset();
        @(negedge clk);
        check(!rst_req && !nmi_req, "R4 reset state", {rst_req, nmi_req}, 0);

        // Vector table: R1, R2, R3, R6, R7
        for (int i = 0; i < 6; i++) begin
            do_reset();
            osc_div2 = VEC[i][3];
            configure(1'b1, VEC[i][4], VEC[i][2:0]);
            kick();
            n = nominal(VEC[i][2:0]);
            measure(1, (n + 2) * (VEC[i][3] ? 2 : 1) + 50, cnt);
            check_window(VEC[i][2:0] == 3'b111 ? "R2 code7 timeout" :
                         (VEC[i][3] ? "R3 div2 timeout" : "R1 timeout"),
                         cnt, n, VEC[i][3] ? 2 : 1);
            if (VEC[i][4]) begin
                check(rst_req && !nmi_req, "R6 reset action", {rst_req, nmi_req}, 2);
                @(negedge clk);
                check(!rst_req, "R6 single-cycle pulse", rst_req, 0);
            end else begin
                check(nmi_req && !rst_req, "R7 nmi action", {rst_req, nmi_req}, 1);
            end
        end
        osc_div2 = 0;

        // R4: enabled but never run
        do_reset();
        configure(1'b1, 1'b0, 3'd0);
        measure(0, 300, cnt);
        check(cnt == 300, "R4 no run no expiry", cnt, 300);

        // R4: run with enable 0
        do_reset();
        configure(1'b0, 1'b0, 3'd0);
        kick();
        measure(1, 300, cnt);
        check(cnt == 300, "R4 disabled no expiry", cnt, 300);

        // R5: repeated run strobes prevent expiry; timeout measured from last
        do_reset();
        configure(1'b1, 1'b0, 3'd1);
        kick();
        for (int k = 0; k < 8; k++) begin
            repeat (90) @(negedge clk);
            kick();
        end
        check(!nmi_req && !rst_req, "R5 strobes prevent expiry", nmi_req, 0);
        measure(1, 200, cnt);
        check_window("R5 timeout from last strobe", cnt, nominal(3'd1), 1);

        // R7: hold, acknowledge, restart
        do_reset();
        configure(1'b1, 1'b0, 3'd0);
        kick();
        measure(1, 200, cnt);
        repeat (20) @(negedge clk);
        check(nmi_req, "R7 nmi held", nmi_req, 1);
        nmi_ack = 1;
        @(negedge clk);
        nmi_ack = 0;
        check(!nmi_req, "R7 ack clears", nmi_req, 0);
        measure(21, 200, cnt);
        check(cnt >= 63 && cnt <= 66, "R7 restart after expiry", cnt, 64);

        // R8: stop freezes counting
        do_reset();
        configure(1'b1, 1'b0, 3'd0);
        kick();
        repeat (10) @(negedge clk);
        cpu_stop = 1;
        measure(0, 400, cnt);
        check(cnt == 400, "R8 stop freezes", cnt, 400);
        cpu_stop = 0;
        measure(11, 200, cnt);
        check_window("R8 resume after stop", cnt, 64, 1);

        // R8: subsystem clock freezes counting
        do_reset();
        configure(1'b1, 1'b0, 3'd0);
        kick();
        repeat (10) @(negedge clk);
        cpu_subclk = 1;
        measure(0, 400, cnt);
        check(cnt == 400, "R8 subclock freezes", cnt, 400);
        cpu_subclk = 0;
        measure(11, 200, cnt);
        check_window("R8 resume after subclock", cnt, 64, 1);

        // R9: configuration locked after run
        do_reset();
        configure(1'b1, 1'b0, 3'd0);
        kick();
        configure(1'b0, 1'b1, 3'd7);
        measure(3, 300, cnt);
        check_window("R9 locked timeout", cnt, 64, 1);
        check(nmi_req && !rst_req, "R9 locked action", {rst_req, nmi_req}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule